// File: doc/BRIEF.md
# Synchronous Clock-Stop Gating Controller

This block stops and restarts a group of generated clock outputs on request, and never cuts a pulse short. The clocks come in already generated. Each one arrives as a level that the block oversamples on its own fast clock. There are two kinds of output. A single-ended output is a plain gated copy of its source. A differential output is a true and complement pair. Every output has two configuration bits: a stoppable bit, which chooses between free-running and stopping on request, and an output-enable bit.

A stop can be requested in two ways. One is an asynchronous active-low pin, which passes through a two-flop synchronizer. The other is a software run bit, which requests a stop while it is 0. The two sources are ORed into one request.

Each output keeps its own gate state and changes it only on a safe phase of its source, so the first and last pulses are always full width. A single-ended gate changes only while its source is low, and a stopped single-ended output rests low. A differential gate changes only while its source is high, and a stopped pair parks with true high and complement low. Each output also reports whether it is stopped.

Top module: `clk_stop_gate`

## Requirements
- R1: The stop pin is active low and is synchronized by two flops. A pin level sampled at clock edge k can first change a gate state at edge k+2. No stopped flag rises at edge k or edge k+1.
- R2: The stop request is active while the software run bit is 0 or while the synchronized pin is low. Setting the run bit to 1 releases a software stop.
- R3: An output whose stoppable bit is 0 never stops. Its stopped flag stays 0 and it keeps toggling while a request is active.
- R4: A stoppable single-ended output stops while a request is active. While stopped it is driven 0 and its stopped flag reads 1.
- R5: A single-ended gate state updates only on an edge where its source level is 0. The gated output is the output-enable bit AND the source AND the gate state, registered once.
- R6: A differential gate state updates only on an edge where its source level is 1. A stopped, enabled pair is driven true=1, complement=0. A running, enabled pair is driven true=source, complement=NOT source, registered once.
- R7: While its output-enable bit is 0, an output is driven 0 whatever the stop state. For a differential pair, both true and complement are driven 0.
- R8: After the request is released, every stopped output is running again within 2 clock cycles plus one period of its source.
- R9: During reset, all clock outputs are 0 and no stopped flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_n_i | input | 1 | Asynchronous active-low stop pin |
| sw_run_i | input | 1 | Software bit: 0 requests a stop, 1 releases it |
| se_stoppable_i | input | N_SE | Per single-ended output: 1 = stops on request |
| se_oe_i | input | N_SE | Per single-ended output enable |
| se_src_i | input | N_SE | Single-ended source clock levels |
| dif_stoppable_i | input | N_DIF | Per differential pair: 1 = stops on request |
| dif_oe_i | input | N_DIF | Per differential pair enable |
| dif_src_i | input | N_DIF | Differential source clock levels |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dif_t_o | output | N_DIF | Gated differential true sides |
| dif_c_o | output | N_DIF | Gated differential complement sides |
| se_stopped_o | output | N_SE | Single-ended stopped flags |
| dif_stopped_o | output | N_DIF | Differential stopped flags |

## Verification
The hardest case to reach is a request that changes while a source sits in the wrong phase for its gate. In that case the gate must wait, and the wait ends differently for single-ended and differential outputs. The bench drives sources with four different periods, and pin and software requests start and end at unrelated points, so the outputs see every alignment of request edge and source phase. A behavioural model then checks every output on every cycle, including when each output stops and when it restarts. Directed windows measure the synchronizer latency and the restart bound, and they hold outputs disabled while a stop is in progress.

// File: rtl/csg_pkg.sv
// Package: shared constants and helpers for the clock-stop gating controller.
// Assumes the gated clocks are levels oversampled by one fast clock.
package csg_pkg;
    localparam int unsigned DEF_N_SE  = 4;
    localparam int unsigned DEF_N_DIF = 2;

    // Resting levels of a stopped, enabled differential pair.
    localparam logic PARK_TRUE = 1'b1;
    localparam logic PARK_COMP = 1'b0;

    // True when a request applies to an output with the given stoppable bit.
    function automatic logic stop_hits(input logic req, input logic stoppable);
        return req & stoppable;
    endfunction
endpackage

// File: rtl/csg_req_sync.sv
// Module: merges the asynchronous stop pin and the software run bit.
// The pin passes through two flops. The run bit is already synchronous.
// Reset leaves the pin path in the released state.
module csg_req_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_n_i,
    input  logic sw_run_i,
    output logic req_o
);
    logic meta_q;
    logic sync_q;

    // Two-flop synchronizer for the active-low stop pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= stop_n_i;
            sync_q <= meta_q;
        end
    end

    // A stop is requested by either source.
    always_comb req_o = !sync_q || !sw_run_i;
endmodule

// File: rtl/csg_se_gate.sv
// Module: gate for one single-ended clock output.
// The gate state moves only while the source is low, so pulses stay whole.
// The output is registered, which puts it one clock after the source.
module csg_se_gate
    import csg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic stoppable_i,
    input  logic oe_i,
    input  logic src_i,
    output logic clk_o,
    output logic stopped_o
);
    logic run_q;

    // Gate state: re-evaluated only in the low phase of the source.
    always_ff @(posedge clk) begin
        if (!rst_n)      run_q <= 1'b1;
        else if (!src_i) run_q <= !stop_hits(req_i, stoppable_i);
    end

    // Registered gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_o <= 1'b0;
        else        clk_o <= oe_i & src_i & run_q;
    end

    always_comb stopped_o = !run_q;

    assert_disabled_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(oe_i) |-> !clk_o);
    assert_stopped_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stopped_o) |-> !clk_o);
    assert_change_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_o != $past(stopped_o)) |-> !$past(src_i));
    assert_stop_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> $past(req_i && stoppable_i));
endmodule

// File: rtl/csg_dif_gate.sv
// Module: gate for one differential clock pair.
// The gate state moves only while the source is high. A stopped pair parks
// true high and complement low, which makes the last high phase longer and
// never shorter. The outputs are registered.
module csg_dif_gate
    import csg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic stoppable_i,
    input  logic oe_i,
    input  logic src_i,
    output logic t_o,
    output logic c_o,
    output logic stopped_o
);
    logic run_q;

    // Gate state: re-evaluated only in the high phase of the source.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= 1'b1;
        else if (src_i) run_q <= !stop_hits(req_i, stoppable_i);
    end

    // Registered pair levels: disabled, running or parked.
    always_ff @(posedge clk) begin
        if (!rst_n || !oe_i) begin
            t_o <= 1'b0;
            c_o <= 1'b0;
        end else if (run_q) begin
            t_o <= src_i;
            c_o <= !src_i;
        end else begin
            t_o <= PARK_TRUE;
            c_o <= PARK_COMP;
        end
    end

    always_comb stopped_o = !run_q;

    assert_park_levels_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stopped_o && oe_i) |-> (t_o && !c_o));
    assert_change_in_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped_o != $past(stopped_o)) |-> $past(src_i));
    assert_pair_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(oe_i) |-> (!t_o && !c_o));
    assert_pair_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped_o) |-> $past(req_i && stoppable_i));
endmodule

// File: rtl/clk_stop_gate.sv
// Module: top of the clock-stop gating controller.
// One request merger feeds a gate per single-ended output and a gate per
// differential pair. Assumes every source level is stable at each clk edge.
module clk_stop_gate #(
    parameter int unsigned N_SE  = csg_pkg::DEF_N_SE,
    parameter int unsigned N_DIF = csg_pkg::DEF_N_DIF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stop_n_i,
    input  logic             sw_run_i,
    input  logic [N_SE-1:0]  se_stoppable_i,
    input  logic [N_SE-1:0]  se_oe_i,
    input  logic [N_SE-1:0]  se_src_i,
    input  logic [N_DIF-1:0] dif_stoppable_i,
    input  logic [N_DIF-1:0] dif_oe_i,
    input  logic [N_DIF-1:0] dif_src_i,
    output logic [N_SE-1:0]  se_clk_o,
    output logic [N_DIF-1:0] dif_t_o,
    output logic [N_DIF-1:0] dif_c_o,
    output logic [N_SE-1:0]  se_stopped_o,
    output logic [N_DIF-1:0] dif_stopped_o
);
    logic req;

    csg_req_sync u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_n_i (stop_n_i),
        .sw_run_i (sw_run_i),
        .req_o    (req)
    );

    // One single-ended gate per output.
    for (genvar i = 0; i < N_SE; i++) begin : g_se
        csg_se_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req),
            .stoppable_i (se_stoppable_i[i]),
            .oe_i        (se_oe_i[i]),
            .src_i       (se_src_i[i]),
            .clk_o       (se_clk_o[i]),
            .stopped_o   (se_stopped_o[i])
        );
    end

    // One differential gate per pair.
    for (genvar j = 0; j < N_DIF; j++) begin : g_dif
        csg_dif_gate u_gate (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_i       (req),
            .stoppable_i (dif_stoppable_i[j]),
            .oe_i        (dif_oe_i[j]),
            .src_i       (dif_src_i[j]),
            .t_o         (dif_t_o[j]),
            .c_o         (dif_c_o[j]),
            .stopped_o   (dif_stopped_o[j])
        );
    end
endmodule

// File: tb/tb_clk_stop_gate.sv
module tb_clk_stop_gate;
    localparam int NS = 4;
    localparam int ND = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_n = 1'b1;
    logic sw_run = 1'b1;
    logic [NS-1:0] se_stp = 4'b0111;
    logic [NS-1:0] se_oe = 4'b1111;
    logic [NS-1:0] se_src = '0;
    logic [ND-1:0] dif_stp = 2'b01;
    logic [ND-1:0] dif_oe = 2'b11;
    logic [ND-1:0] dif_src = '0;
    logic [NS-1:0] se_clk, se_stopped;
    logic [ND-1:0] dif_t, dif_c, dif_stopped;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    clk_stop_gate dut (
        .clk(clk), .rst_n(rst_n), .stop_n_i(stop_n), .sw_run_i(sw_run),
        .se_stoppable_i(se_stp), .se_oe_i(se_oe), .se_src_i(se_src),
        .dif_stoppable_i(dif_stp), .dif_oe_i(dif_oe), .dif_src_i(dif_src),
        .se_clk_o(se_clk), .dif_t_o(dif_t), .dif_c_o(dif_c),
        .se_stopped_o(se_stopped), .dif_stopped_o(dif_stopped)
    );

    // Source clocks: periods 4,6,8,10 (single-ended) and 4,6 (pairs), first half high.
    int se_per[NS] = '{4, 6, 8, 10};
    int dif_per[ND] = '{4, 6};
    int tick = 0;
    always @(negedge clk) begin
        tick = tick + 1;
        for (int i = 0; i < NS; i++) se_src[i] = (tick % se_per[i]) < se_per[i] / 2;
        for (int j = 0; j < ND; j++) dif_src[j] = (tick % dif_per[j]) < dif_per[j] / 2;
    end

    // Behavioural reference model, advanced on every rising edge.
    logic pin_hist[$];
    bit m_se_run[NS], m_dif_run[ND];
    logic [NS-1:0] m_se_clk;
    logic [ND-1:0] m_t, m_c;
    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist = '{1'b1, 1'b1};
            for (int i = 0; i < NS; i++) m_se_run[i] = 1;
            for (int j = 0; j < ND; j++) m_dif_run[j] = 1;
            m_se_clk = '0; m_t = '0; m_c = '0;
        end else begin
            bit req;
            req = (pin_hist[0] == 1'b0) || (sw_run == 1'b0);
            pin_hist.pop_front();
            pin_hist.push_back(stop_n);
            for (int i = 0; i < NS; i++) begin
                m_se_clk[i] = se_oe[i] && se_src[i] && m_se_run[i];
                if (!se_src[i]) m_se_run[i] = !(req && se_stp[i]);
            end
            for (int j = 0; j < ND; j++) begin
                if (!dif_oe[j]) begin m_t[j] = 0; m_c[j] = 0; end
                else if (m_dif_run[j]) begin m_t[j] = dif_src[j]; m_c[j] = !dif_src[j]; end
                else begin m_t[j] = 1; m_c[j] = 0; end
                if (dif_src[j]) m_dif_run[j] = !(req && dif_stp[j]);
            end
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NS-1:0] ms;
            logic [ND-1:0] md;
            for (int i = 0; i < NS; i++) ms[i] = !m_se_run[i];
            for (int j = 0; j < ND; j++) md[j] = !m_dif_run[j];
            check("R5 single-ended clocks", 8'(se_clk), 8'(m_se_clk));
            check("R6 pair true sides", 8'(dif_t), 8'(m_t));
            check("R6 pair complement sides", 8'(dif_c), 8'(m_c));
            check("R4 single-ended stopped flags", 8'(se_stopped), 8'(ms));
            check("R6 pair stopped flags", 8'(dif_stopped), 8'(md));
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    // Waits until no output is stopped, counting cycles, and checks the R8 bound.
    task automatic expect_restart(input string tag);
        int n = 0;
        while ((se_stopped != 0 || dif_stopped != 0) && n < 40) begin
            @(negedge clk); n++;
        end
        check(tag, 8'(n <= 12), 8'd1);
    endtask

    initial begin
        bit saw_high;
        repeat (3) @(negedge clk);
        // R9: state during reset
        check("R9 clocks low in reset", 8'({se_clk, dif_t, dif_c}), 8'd0);
        check("R9 no stopped flag in reset", 8'({se_stopped, dif_stopped}), 8'd0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R1: pin drop sampled at edge k; no flag before edge k+2
        stop_n = 1'b0;
        @(negedge clk);
        check("R1 no stop after first edge", 8'({se_stopped, dif_stopped}), 8'd0);
        @(negedge clk);
        check("R1 no stop after second edge", 8'({se_stopped, dif_stopped}), 8'd0);
        repeat (12) @(negedge clk);
        check("R4 stoppable single-ended stopped", 8'(se_stopped), 8'b0111);
        check("R4 stopped outputs low", 8'(se_clk & 4'b0111), 8'd0);
        check("R6 parked pair levels", 8'({dif_t[0], dif_c[0], dif_stopped[0]}), 8'b101);
        saw_high = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (se_clk[3]) saw_high = 1;
        end
        check("R3 free-running output not stopped", 8'({se_stopped[3], dif_stopped[1]}), 8'd0);
        check("R3 free-running output toggles", 8'(saw_high), 8'd1);

        // R8: restart bound after pin release
        stop_n = 1'b1;
        @(negedge clk);
        expect_restart("R8 restart after pin release");

        // R2: software stop and release
        repeat (5) @(negedge clk);
        sw_run = 1'b0;
        repeat (14) @(negedge clk);
        check("R2 software stop", 8'({se_stopped, dif_stopped}), 8'b011101);
        sw_run = 1'b1;
        @(negedge clk);
        expect_restart("R8 restart after software release");

        // R7: disabled outputs are low, with and without a stop
        se_oe[0] = 1'b0; se_oe[3] = 1'b0; dif_oe = 2'b00;
        @(negedge clk);
        for (int k = 0; k < 30; k++) begin
            if (k == 10) sw_run = 1'b0;
            @(negedge clk);
            check("R7 disabled outputs low", 8'({se_clk[0], se_clk[3], dif_t, dif_c}), 8'd0);
        end
        sw_run = 1'b1;
        se_oe = 4'b1111; dif_oe = 2'b11;
        @(negedge clk);
        expect_restart("R8 restart after stop while disabled");

        // Mixed pattern: overlapping pin and software requests
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (k % 37 == 5) stop_n = ~stop_n;
            if (k % 23 == 11) sw_run = ~sw_run;
            if (k % 41 == 20) se_stp = se_stp ^ 4'b1001;
        end
        stop_n = 1'b1; sw_run = 1'b1;
        repeat (30) @(negedge clk);
        summary();
    end
endmodule